// File: doc/BRIEF.md
# Listen Time Window Evaluator

This block judges, once per poll strobe, whether the receive front end should become more or less tolerant of noise. It takes three free-running hardware counters: total clock cycles, cycles spent busy receiving and cycles spent busy transmitting. From the change in these counters since the previous poll it works out how many milliseconds the radio spent idle and listening. That figure is added to a window accumulator, together with the OFDM and CCK error counts reported for the same interval.

Once the window holds more than one period of listen time, the block compares the error counts against high-rate thresholds scaled to that time. It raises an OFDM request when the OFDM errors are too many, and only otherwise a CCK request. Once the window holds more than five periods, it issues a lower-immunity request, but only when both error counts sit under their low-rate thresholds. Each decision restarts the window. All results are single-cycle registered pulses that appear on the cycle after the poll strobe.

Top module: `listen_win_eval`

## Requirements
- R1: After reset every pulse output is 0, the listen time and both error counts read 0, and the stored previous counter values are 0, so the first enabled poll is treated as an initial sample.
- R2: When the stored previous cycle value is 0, or is greater than the present cycle value, the poll adds 0 ms and pulses `zero_evt_o`.
- R3: Otherwise the poll adds (cycle delta − receive delta − transmit delta) / CYC_PER_MS ms. Each delta is taken modulo 2^CNT_W and read as a signed value, and the division truncates toward zero, so a small negative remainder yields 0.
- R4: Every enabled poll stores its cycle, receive and transmit values as the reference for the next enabled poll, whichever branch the poll takes.
- R5: A negative per-poll listen time pulses `neg_evt_o` and `restart_o`, leaves the window empty (time and both counts 0), and issues no request.
- R6: Each enabled poll adds `ofdm_err_i` and `cck_err_i` to the window error counts, saturating at all ones, before the poll is judged.
- R7: When the window time exceeds 5×`period_i`, the window restarts. `lower_o` pulses only when OFDM count ≤ floor(time×`ofdm_lo_i`/1000) and CCK count ≤ floor(time×`cck_lo_i`/1000). No raise is issued on this branch.
- R8: When the window time exceeds `period_i` but not 5×`period_i`, `raise_ofdm_o` and a restart occur if OFDM count > floor(time×`ofdm_hi_i`/1000). Only when that test fails, `raise_cck_o` and a restart occur if CCK count > floor(time×`cck_hi_i`/1000). If neither test fires, the window keeps accumulating.
- R9: At most one of `raise_ofdm_o`, `raise_cck_o`, `lower_o` is high in any cycle, and each of them is accompanied by `restart_o`. A restart empties the window.
- R10: While `enable_i` is low, a poll changes nothing: no pulse, no change to the window, and no update of the stored counter references.
- R11: Pulses last exactly one cycle after the poll. Without an enabled poll every pulse is 0 and the window holds its value.
- R12: The rate scaling uses an ACC_W+RATE_W bit product. A time of 70000 ms at a rate of 65535 gives a limit of 4587450, with no 32-bit wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Global evaluation enable |
| poll_i | input | 1 | Poll strobe, one cycle |
| cyc_cnt_i | input | CNT_W | Free-running cycle counter |
| rx_busy_i | input | CNT_W | Receive-busy cycle counter |
| tx_busy_i | input | CNT_W | Transmit-busy cycle counter |
| ofdm_err_i | input | ERR_W | OFDM errors since the previous poll |
| cck_err_i | input | ERR_W | CCK errors since the previous poll |
| period_i | input | PER_W | Window period in ms |
| ofdm_hi_i | input | RATE_W | OFDM raise rate, errors per second |
| ofdm_lo_i | input | RATE_W | OFDM lower rate, errors per second |
| cck_hi_i | input | RATE_W | CCK raise rate, errors per second |
| cck_lo_i | input | RATE_W | CCK lower rate, errors per second |
| raise_ofdm_o | output | 1 | Raise request driven by OFDM errors |
| raise_cck_o | output | 1 | Raise request driven by CCK errors |
| lower_o | output | 1 | Lower-immunity request |
| restart_o | output | 1 | Window restarted |
| zero_evt_o | output | 1 | Poll treated as initial or wrapped sample |
| neg_evt_o | output | 1 | Poll gave a negative listen time |
| listen_ms_o | output | ACC_W | Accumulated window listen time, ms |
| ofdm_cnt_o | output | ERR_W | Window OFDM error count |
| cck_cnt_o | output | ERR_W | Window CCK error count |

## Verification
The bench overrides CYC_PER_MS to 1000 and keeps the 32-bit counters and 16-bit rates. Each poll then adds a few tens of milliseconds, so short windows, five-period windows, truncation of negative remainders and deliberately inconsistent busy counts all come up within a few hundred random polls. Because the rate and period inputs keep their full 16-bit range, a directed case can push time×rate past 2^32 and show that the widened product gives the correct limit.

// File: rtl/lwe_pkg.sv
package lwe_pkg;

  // thresholds are given per second, listen time is in ms
  localparam int unsigned RATE_SCALE = 1000;

  typedef struct packed {
    logic raise_ofdm;
    logic raise_cck;
    logic lower;
    logic restart;
  } lwe_verdict_t;

endpackage

// File: rtl/lwe_listen.sv
module lwe_listen #(
  parameter int CNT_W      = 32,
  parameter int CYC_PER_MS = 44000,
  localparam int LT_W      = CNT_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take_i,
  input  logic [CNT_W-1:0]       cyc_i,
  input  logic [CNT_W-1:0]       rx_i,
  input  logic [CNT_W-1:0]       tx_i,
  output logic signed [LT_W-1:0] lt_o,
  output logic                   first_o
);

  localparam logic signed [LT_W-1:0] DIV_S = LT_W'(CYC_PER_MS);

  logic [CNT_W-1:0] prev_cyc_q, prev_rx_q, prev_tx_q;

  // idle cycles over the interval, converted to ms (truncating toward zero)
  function automatic logic signed [LT_W-1:0] idle_ms(
    input logic [CNT_W-1:0] dc,
    input logic [CNT_W-1:0] dr,
    input logic [CNT_W-1:0] dt
  );
    logic signed [LT_W-1:0] free_cycles;
    free_cycles = LT_W'($signed(dc)) - LT_W'($signed(dr)) - LT_W'($signed(dt));
    return free_cycles / DIV_S;
  endfunction

  assign first_o = (prev_cyc_q == '0) || (prev_cyc_q > cyc_i);
  assign lt_o    = first_o ? '0
                           : idle_ms(cyc_i - prev_cyc_q, rx_i - prev_rx_q, tx_i - prev_tx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cyc_q <= '0;
      prev_rx_q  <= '0;
      prev_tx_q  <= '0;
    end else if (take_i) begin
      prev_cyc_q <= cyc_i;
      prev_rx_q  <= rx_i;
      prev_tx_q  <= tx_i;
    end
  end

  AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(prev_cyc_q) && $stable(prev_rx_q) && $stable(prev_tx_q)); // R10

endmodule

// File: rtl/lwe_judge.sv
module lwe_judge
  import lwe_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ERR_W  = 32,
  parameter int PER_W  = 16,
  parameter int RATE_W = 16,
  localparam int PROD_W = ACC_W + RATE_W,
  localparam int CMP_W  = (ERR_W > PROD_W) ? ERR_W : PROD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ERR_W-1:0]  ofdm_i,
  input  logic [ERR_W-1:0]  cck_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [RATE_W-1:0] ofdm_hi_i,
  input  logic [RATE_W-1:0] ofdm_lo_i,
  input  logic [RATE_W-1:0] cck_hi_i,
  input  logic [RATE_W-1:0] cck_lo_i,
  output lwe_verdict_t      verdict_o
);

  // error budget for t ms at r errors per second, in a product wide enough not to wrap
  function automatic logic [CMP_W-1:0] err_limit(
    input logic [ACC_W-1:0]  t,
    input logic [RATE_W-1:0] r
  );
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(t) * PROD_W'(r);
    return CMP_W'(prod / PROD_W'(RATE_SCALE));
  endfunction

  logic [ACC_W-1:0] short_lim, long_lim;
  logic             short_win, long_win;
  logic [CMP_W-1:0] ofdm_w, cck_w;
  logic [CMP_W-1:0] lim_oh, lim_ol, lim_ch, lim_cl;

  assign short_lim = ACC_W'(period_i);
  assign long_lim  = ACC_W'(period_i) * ACC_W'(5);
  assign short_win = acc_i > short_lim;
  assign long_win  = acc_i > long_lim;

  assign ofdm_w = CMP_W'(ofdm_i);
  assign cck_w  = CMP_W'(cck_i);
  assign lim_oh = err_limit(acc_i, ofdm_hi_i);
  assign lim_ol = err_limit(acc_i, ofdm_lo_i);
  assign lim_ch = err_limit(acc_i, cck_hi_i);
  assign lim_cl = err_limit(acc_i, cck_lo_i);

  always_comb begin
    verdict_o = '0;
    if (valid_i) begin
      if (long_win) begin
        verdict_o.restart = 1'b1;
        verdict_o.lower   = (ofdm_w <= lim_ol) && (cck_w <= lim_cl);
      end else if (short_win) begin
        if (ofdm_w > lim_oh) begin
          verdict_o.raise_ofdm = 1'b1;
          verdict_o.restart    = 1'b1;
        end else if (cck_w > lim_ch) begin
          verdict_o.raise_cck = 1'b1;
          verdict_o.restart   = 1'b1;
        end
      end
    end
  end

  AST_LONG_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && long_win) |-> !verdict_o.raise_ofdm && !verdict_o.raise_cck && verdict_o.restart); // R7
  AST_SHORT_ONLY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !short_win) |-> verdict_o == '0); // R8

endmodule

// File: rtl/listen_win_eval.sv
module listen_win_eval
  import lwe_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int CYC_PER_MS = 44000,
  parameter int ACC_W      = 32,
  parameter int ERR_W      = 32,
  parameter int PER_W      = 16,
  parameter int RATE_W     = 16,
  localparam int LT_W      = CNT_W + 2,
  localparam int SUM_W     = ((ACC_W > LT_W) ? ACC_W : LT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              poll_i,
  input  logic [CNT_W-1:0]  cyc_cnt_i,
  input  logic [CNT_W-1:0]  rx_busy_i,
  input  logic [CNT_W-1:0]  tx_busy_i,
  input  logic [ERR_W-1:0]  ofdm_err_i,
  input  logic [ERR_W-1:0]  cck_err_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [RATE_W-1:0] ofdm_hi_i,
  input  logic [RATE_W-1:0] ofdm_lo_i,
  input  logic [RATE_W-1:0] cck_hi_i,
  input  logic [RATE_W-1:0] cck_lo_i,
  output logic              raise_ofdm_o,
  output logic              raise_cck_o,
  output logic              lower_o,
  output logic              restart_o,
  output logic              zero_evt_o,
  output logic              neg_evt_o,
  output logic [ACC_W-1:0]  listen_ms_o,
  output logic [ERR_W-1:0]  ofdm_cnt_o,
  output logic [ERR_W-1:0]  cck_cnt_o
);

  // saturating add of a non-negative poll time to the window time
  function automatic logic [ACC_W-1:0] acc_add(
    input logic [ACC_W-1:0]       a,
    input logic signed [LT_W-1:0] d
  );
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'($unsigned(d));
    return (s > SUM_W'({ACC_W{1'b1}})) ? {ACC_W{1'b1}} : ACC_W'(s);
  endfunction

  function automatic logic [ERR_W-1:0] err_add(
    input logic [ERR_W-1:0] a,
    input logic [ERR_W-1:0] b
  );
    logic [ERR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ERR_W] ? {ERR_W{1'b1}} : s[ERR_W-1:0];
  endfunction

  logic                   take;
  logic signed [LT_W-1:0] poll_ms;
  logic                   poll_first;
  logic                   poll_neg;
  logic [ACC_W-1:0]       acc_q, acc_next;
  logic [ERR_W-1:0]       ofdm_q, cck_q, ofdm_next, cck_next;
  lwe_verdict_t           verdict;

  assign take = poll_i && enable_i;

  lwe_listen #(
    .CNT_W      (CNT_W),
    .CYC_PER_MS (CYC_PER_MS)
  ) listen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .cyc_i   (cyc_cnt_i),
    .rx_i    (rx_busy_i),
    .tx_i    (tx_busy_i),
    .lt_o    (poll_ms),
    .first_o (poll_first)
  );

  assign poll_neg  = poll_ms < 0;
  assign acc_next  = acc_add(acc_q, poll_ms);
  assign ofdm_next = err_add(ofdm_q, ofdm_err_i);
  assign cck_next  = err_add(cck_q, cck_err_i);

  lwe_judge #(
    .ACC_W  (ACC_W),
    .ERR_W  (ERR_W),
    .PER_W  (PER_W),
    .RATE_W (RATE_W)
  ) judge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (take && !poll_neg),
    .acc_i     (acc_next),
    .ofdm_i    (ofdm_next),
    .cck_i     (cck_next),
    .period_i  (period_i),
    .ofdm_hi_i (ofdm_hi_i),
    .ofdm_lo_i (ofdm_lo_i),
    .cck_hi_i  (cck_hi_i),
    .cck_lo_i  (cck_lo_i),
    .verdict_o (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q        <= '0;
      ofdm_q       <= '0;
      cck_q        <= '0;
      raise_ofdm_o <= 1'b0;
      raise_cck_o  <= 1'b0;
      lower_o      <= 1'b0;
      restart_o    <= 1'b0;
      zero_evt_o   <= 1'b0;
      neg_evt_o    <= 1'b0;
    end else begin
      raise_ofdm_o <= take && verdict.raise_ofdm;
      raise_cck_o  <= take && verdict.raise_cck;
      lower_o      <= take && verdict.lower;
      restart_o    <= take && (poll_neg || verdict.restart);
      zero_evt_o   <= take && poll_first;
      neg_evt_o    <= take && poll_neg;
      if (take) begin
        if (poll_neg || verdict.restart) begin
          acc_q  <= '0;
          ofdm_q <= '0;
          cck_q  <= '0;
        end else begin
          acc_q  <= acc_next;
          ofdm_q <= ofdm_next;
          cck_q  <= cck_next;
        end
      end
    end
  end

  assign listen_ms_o = acc_q;
  assign ofdm_cnt_o  = ofdm_q;
  assign cck_cnt_o   = cck_q;

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({raise_ofdm_o, raise_cck_o, lower_o})); // R9
  AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_ofdm_o || raise_cck_o || lower_o) |-> restart_o); // R9
  AST_RESTART_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (listen_ms_o == '0) && (ofdm_cnt_o == '0) && (cck_cnt_o == '0)); // R5
  AST_NEG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    neg_evt_o |-> restart_o && !raise_ofdm_o && !raise_cck_o && !lower_o); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !raise_ofdm_o && !raise_cck_o && !lower_o && !restart_o
              && !zero_evt_o && !neg_evt_o); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(listen_ms_o) && $stable(ofdm_cnt_o) && $stable(cck_cnt_o)); // R10

endmodule

// File: tb/listen_win_eval_tb_top.sv
module listen_win_eval_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  CPM        = 1000;
  localparam longint ACC_MAX = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0, poll_i = 1'b0;
  logic [31:0] cyc_cnt_i = '0, rx_busy_i = '0, tx_busy_i = '0;
  logic [31:0] ofdm_err_i = '0, cck_err_i = '0;
  logic [15:0] period_i = '0, ofdm_hi_i = '0, ofdm_lo_i = '0, cck_hi_i = '0, cck_lo_i = '0;
  logic        raise_ofdm_o, raise_cck_o, lower_o, restart_o, zero_evt_o, neg_evt_o;
  logic [31:0] listen_ms_o, ofdm_cnt_o, cck_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  listen_win_eval #(.CYC_PER_MS(CPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .poll_i(poll_i),
    .cyc_cnt_i(cyc_cnt_i), .rx_busy_i(rx_busy_i), .tx_busy_i(tx_busy_i),
    .ofdm_err_i(ofdm_err_i), .cck_err_i(cck_err_i), .period_i(period_i),
    .ofdm_hi_i(ofdm_hi_i), .ofdm_lo_i(ofdm_lo_i), .cck_hi_i(cck_hi_i), .cck_lo_i(cck_lo_i),
    .raise_ofdm_o(raise_ofdm_o), .raise_cck_o(raise_cck_o), .lower_o(lower_o),
    .restart_o(restart_o), .zero_evt_o(zero_evt_o), .neg_evt_o(neg_evt_o),
    .listen_ms_o(listen_ms_o), .ofdm_cnt_o(ofdm_cnt_o), .cck_cnt_o(cck_cnt_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench reference state
  bit [31:0] m_pc = 0, m_pr = 0, m_pt = 0;
  longint    m_acc = 0, m_of = 0, m_ck = 0;
  bit [31:0] cur_c = 0, cur_r = 0, cur_t = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint budget(input longint t, input longint rate);
    return (t * rate) / 1000;
  endfunction

  // one poll: drive, predict, compare, then confirm the pulses drop
  task automatic do_poll(input string tag, input bit en, input bit [31:0] io, input bit [31:0] ic);
    bit [5:0] exp_p;
    bit       first, rst_w;
    longint   lt;
    exp_p = '0;
    @(negedge clk);
    enable_i = en; poll_i = 1'b1;
    cyc_cnt_i = cur_c; rx_busy_i = cur_r; tx_busy_i = cur_t;
    ofdm_err_i = io; cck_err_i = ic;
    if (en) begin
      first = (m_pc == 0) || (m_pc > cur_c);
      lt = first ? 0 : (longint'(int'(cur_c - m_pc)) - longint'(int'(cur_r - m_pr))
                        - longint'(int'(cur_t - m_pt))) / CPM;
      m_pc = cur_c; m_pr = cur_r; m_pt = cur_t;
      exp_p[1] = first;
      if (lt < 0) begin
        exp_p[0] = 1'b1; exp_p[2] = 1'b1;
        m_acc = 0; m_of = 0; m_ck = 0;
      end else begin
        rst_w = 1'b0;
        m_acc = (m_acc + lt > ACC_MAX) ? ACC_MAX : m_acc + lt;
        m_of = (m_of + io > ACC_MAX) ? ACC_MAX : m_of + io;
        m_ck = (m_ck + ic > ACC_MAX) ? ACC_MAX : m_ck + ic;
        if (m_acc > 5 * longint'(period_i)) begin
          rst_w = 1'b1;
          exp_p[3] = (m_of <= budget(m_acc, ofdm_lo_i)) && (m_ck <= budget(m_acc, cck_lo_i));
        end else if (m_acc > longint'(period_i)) begin
          if (m_of > budget(m_acc, ofdm_hi_i)) begin exp_p[5] = 1'b1; rst_w = 1'b1; end
          else if (m_ck > budget(m_acc, cck_hi_i)) begin exp_p[4] = 1'b1; rst_w = 1'b1; end
        end
        exp_p[2] = rst_w;
        if (rst_w) begin m_acc = 0; m_of = 0; m_ck = 0; end
      end
    end
    @(negedge clk);
    poll_i = 1'b0; ofdm_err_i = '0; cck_err_i = '0;
    check({tag, " pulses"}, {raise_ofdm_o, raise_cck_o, lower_o, restart_o, zero_evt_o, neg_evt_o}, exp_p);
    check({tag, " listen_ms"}, listen_ms_o, m_acc);
    check({tag, " ofdm_cnt R6"}, ofdm_cnt_o, m_of);
    check({tag, " cck_cnt R6"}, cck_cnt_o, m_ck);
    check({tag, " one-hot R9"}, $countones({raise_ofdm_o, raise_cck_o, lower_o}) > 1, 0);
    @(negedge clk);
    check("R11 pulse drop", {raise_ofdm_o, raise_cck_o, lower_o, restart_o, zero_evt_o, neg_evt_o}, 0);
  endtask

  task automatic step(input string tag, input bit [31:0] dc, input bit [31:0] dr,
                      input bit [31:0] dt, input bit [31:0] io, input bit [31:0] ic);
    cur_c += dc; cur_r += dr; cur_t += dt;
    do_poll(tag, 1'b1, io, ic);
  endtask

  task automatic set_rates(input int p, input int oh, input int ol, input int ch, input int cl);
    period_i = 16'(p); ofdm_hi_i = 16'(oh); ofdm_lo_i = 16'(ol);
    cck_hi_i = 16'(ch); cck_lo_i = 16'(cl);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pulses", {raise_ofdm_o, raise_cck_o, lower_o, restart_o, zero_evt_o, neg_evt_o}, 0);
    check("R1 reset window", {listen_ms_o, ofdm_cnt_o, cck_cnt_o}, 0);

    set_rates(10, 1000, 0, 1000, 0);
    cur_c = 32'd5000;
    do_poll("R1 R2 first poll", 1'b1, 2, 1);
    step("R3 plain delta", 5500, 1000, 1000, 2, 0);
    step("R3 R4 next delta", 4000, 500, 0, 1, 1);
    cur_c = 32'd100;
    do_poll("R2 wrapped cycle", 1'b1, 0, 0);
    step("R5 negative", 1000, 2500, 1000, 3, 3);
    step("R3 truncation", 1000, 1000, 500, 0, 0);
    // disabled poll: nothing moves, reference kept
    cur_c += 50000;
    do_poll("R10 disabled", 1'b0, 999, 999);
    step("R4 R10 after disable", 2000, 0, 0, 0, 0);

    set_rates(10, 1000, 0, 1000, 0);
    step("R5 clear", 0, 5000, 0, 0, 0);
    step("R8 both high, OFDM wins", 11000, 0, 0, 50, 50);
    step("R8 CCK raise", 11000, 0, 0, 11, 12);
    step("R8 no raise at limit", 11000, 0, 0, 11, 11);
    step("R5 clear", 0, 5000, 0, 0, 0);
    set_rates(4, 1000, 0, 1000, 0);
    for (int k = 0; k < 7; k++) step("R7 long window build", 3000, 0, 0, 0, 0);
    set_rates(4, 65535, 100, 65535, 100);
    step("R5 clear", 0, 5000, 0, 0, 0);
    for (int k = 0; k < 7; k++) step("R7 long window no lower", 3000, 0, 0, 1, 0);

    set_rates(60000, 65535, 0, 65535, 0);
    step("R5 clear", 0, 5000, 0, 0, 0);
    step("R12 wide product raise", 70000000, 0, 0, 4587451, 0);
    step("R5 clear", 0, 5000, 0, 0, 0);
    step("R12 wide product hold", 70000000, 0, 0, 4587450, 0);

    for (int n = 0; n < 320; n++) begin
      int sel;
      bit [31:0] dc, dr, dt, io, ic;
      sel = $urandom_range(0, 31);
      if (n % 40 == 0)
        set_rates($urandom_range(5, 60), $urandom_range(100, 5000), $urandom_range(0, 400),
                  $urandom_range(100, 5000), $urandom_range(0, 400));
      dc = $urandom_range(0, 40 * CPM);
      dr = $urandom_range(0, dc / 2);
      dt = $urandom_range(0, dc / 2);
      if (sel < 2) dr = dc + $urandom_range(1, 5000);
      io = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 100);
      ic = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 100);
      if (sel == 3) begin
        cur_c = $urandom_range(0, 1000);
        do_poll("R2 random wrap", 1'b1, io, ic);
      end else if (sel == 4) begin
        cur_c += dc;
        do_poll("R10 random disabled", 1'b0, io, ic);
      end else begin
        step("R3 R7 R8 random", dc, dr, dt, io, ic);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule